// File: doc/BRIEF.md
# Spike-count buffer memory

This block is an on-chip buffer placed between spiking processing elements. A producer sends a unary spike train (one bit per cycle) along with an entry index. The block counts the spikes that arrive in one sampling window and stores only that count. A consumer later asks for an entry by index. The block reads the count back and emits a new spike train that holds exactly that many spikes across one sampling window.

The window length is 2^n cycles. The exponent n is a run-time setting on the `cfg_exp` input, which is held stable while any window is active. Each entry takes n bits. The storage is addressed by bit, so entry i occupies bits i*n through i*n+n-1 with no gaps between entries. The 16 Kb store is split into two word-wide SRAM banks, one for even words and one for odd words. A field that straddles a word boundary is therefore written and read in a single access.

On the output side there is a single port with a busy flag. One read request can be held while the port is busy. Each window runs to completion, and the next one starts only after it has ended.

Top module: `spike_count_buffer`

## Requirements
- R1: While reset is asserted and right after it is released, `busy` and `spike_out` are both 0.
- R2: When `win_start` is sampled high and no capture is running, a capture window of 2^n cycles begins. That sampling cycle is the first window cycle. Every `in_spike` high within the window is counted. The count is stored as an n-bit field at bit address `in_addr`*n, and it can be read two cycles after the last window cycle.
- R3: A window count of 2^n is stored as 2^n-1. Counts below 2^n are stored unchanged.
- R4: A `win_start` pulse during a running capture window is ignored. That pulse does not change the captured index or the window timing. `in_spike` values outside any window are not counted.
- R5: Fields are packed at bit granularity for any n from 1 to 8. Writing one entry leaves the neighbouring entries unchanged, including fields that cross a 16-bit word boundary in either bank order.
- R6: The spike train regenerated for a read contains exactly the stored count of spikes within its 2^n-cycle window.
- R7: A read request sampled while `busy` is 0 is accepted, and `busy` is 1 in the next cycle. The output window covers cycles 3 to 2^n+2 after the sampling edge. `spike_out` is 0 in the two cycles before it.
- R8: A read request sampled while `busy` is 1 is held, not dropped. After the current window ends, `busy` stays 1 and the held request is served. The two windows never overlap.
- R9: `busy` stays 1 for the whole output window. It falls in the cycle after the last window cycle when no request is held or arriving, and `spike_out` is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_exp | input | 4 | Window exponent n (1..8); window is 2^n cycles |
| win_start | input | 1 | Starts a capture window when no capture is running |
| in_addr | input | 14 | Entry index of the capture, sampled with `win_start` |
| in_spike | input | 1 | Incoming spike train |
| rd_req | input | 1 | Read request, one cycle |
| rd_addr | input | 14 | Entry index of the read |
| spike_out | output | 1 | Regenerated spike train |
| busy | output | 1 | Output port is fetching or emitting a window |

## Verification
The hardest case to reach from the ports is a held read chained directly after a running window. In that case `busy` never drops, and only the two silent fetch cycles mark the boundary between the windows. The bench raises a second request a few cycles into a 16-cycle window, and its monitor uses cycle counting to separate the windows. Fields that span an odd-to-even or even-to-odd word boundary are reached by choosing n = 3 and n = 5 with entry indices whose bit offsets cross bits 16 and 32. Saturation is reached by driving an all-ones train.

// File: rtl/scb_pkg.sv
package scb_pkg;
   typedef enum logic [1:0] {RD_IDLE, RD_FETCH, RD_LOAD, RD_PLAY} rd_state_t;
endpackage

// File: rtl/scb_collector.sv
// Input side: counts spikes over one window and issues a saturated field write.
module scb_collector #(
   parameter int ADDR_W  = 14,
   parameter int EXP_MAX = 8,
   parameter int EXP_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [EXP_W-1:0]   cfg_exp,
   input  logic               win_start,
   input  logic [ADDR_W-1:0]  in_addr,
   input  logic               in_spike,
   output logic               wr_en,
   output logic [ADDR_W-1:0]  wr_bitaddr,
   output logic [EXP_MAX-1:0] wr_cnt
);
   localparam int CNT_W = EXP_MAX + 1;

   logic             active;
   logic [CNT_W-1:0] cyc, cnt, cnt_nxt, win_len;

   always_comb begin
      win_len = CNT_W'(1) << cfg_exp;
      cnt_nxt = cnt + CNT_W'(in_spike);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active     <= 1'b0;
         cyc        <= '0;
         cnt        <= '0;
         wr_en      <= 1'b0;
         wr_bitaddr <= '0;
         wr_cnt     <= '0;
      end else begin
         wr_en <= 1'b0;
         if (!active) begin
            if (win_start) begin
               active     <= 1'b1;
               cyc        <= CNT_W'(1);
               cnt        <= CNT_W'(in_spike);
               wr_bitaddr <= in_addr * ADDR_W'(cfg_exp);
            end
         end else begin
            cnt <= cnt_nxt;
            cyc <= cyc + CNT_W'(1);
            if (cyc == win_len - CNT_W'(1)) begin
               active <= 1'b0;
               wr_en  <= 1'b1;
               wr_cnt <= (cnt_nxt >= win_len) ? EXP_MAX'(win_len - CNT_W'(1))
                                              : EXP_MAX'(cnt_nxt);
            end
         end
      end
   end
endmodule

// File: rtl/scb_bank.sv
// One word-wide SRAM bank with bit-masked write and registered read.
module scb_bank #(
   parameter int WORD_W = 16,
   parameter int ROW_W  = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ROW_W-1:0]  waddr,
   input  logic [WORD_W-1:0] wmask,
   input  logic [WORD_W-1:0] wdata,
   input  logic [ROW_W-1:0]  raddr,
   output logic [WORD_W-1:0] rdata
);
   localparam int ROWS = 1 << ROW_W;

   logic [WORD_W-1:0] mem [ROWS];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/scb_player.sv
// Output side: accepts/holds reads, fetches a count and replays it as spikes.
module scb_player
   import scb_pkg::*;
#(
   parameter int ADDR_W  = 14,
   parameter int EXP_MAX = 8,
   parameter int EXP_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [EXP_W-1:0]   cfg_exp,
   input  logic               rd_req,
   input  logic [ADDR_W-1:0]  rd_addr,
   input  logic [EXP_MAX-1:0] fetch_cnt,
   output logic [ADDR_W-1:0]  fetch_addr,
   output logic               busy,
   output logic               playing,
   output logic               spike_out
);
   localparam int CNT_W = EXP_MAX + 1;

   rd_state_t          state;
   logic               pend_v, last, take;
   logic [ADDR_W-1:0]  pend_addr, src_addr;
   logic [CNT_W-1:0]   acc, cyc, win_len, sum;
   logic [EXP_MAX-1:0] k;

   always_comb begin
      win_len  = CNT_W'(1) << cfg_exp;
      sum      = acc + CNT_W'(k);
      last     = (state == RD_PLAY) && (cyc == win_len - CNT_W'(1));
      take     = (state == RD_IDLE) ? rd_req : (last && (pend_v || rd_req));
      src_addr = pend_v ? pend_addr : rd_addr;
   end

   assign busy      = (state != RD_IDLE);
   assign playing   = (state == RD_PLAY);
   assign spike_out = playing && (sum >= win_len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= RD_IDLE;
         pend_v     <= 1'b0;
         pend_addr  <= '0;
         acc        <= '0;
         cyc        <= '0;
         k          <= '0;
         fetch_addr <= '0;
      end else begin
         case (state)
            RD_FETCH: state <= RD_LOAD;
            RD_LOAD: begin
               state <= RD_PLAY;
               k     <= fetch_cnt;
               acc   <= '0;
               cyc   <= '0;
            end
            RD_PLAY: begin
               acc <= spike_out ? sum - win_len : sum;
               cyc <= cyc + CNT_W'(1);
               if (last) state <= RD_IDLE;
            end
            default: ;
         endcase
         if (take) begin
            state      <= RD_FETCH;
            fetch_addr <= src_addr * ADDR_W'(cfg_exp);
         end
         if (busy && rd_req && !(take && !pend_v)) begin
            pend_v    <= 1'b1;
            pend_addr <= rd_addr;
         end else if (take && pend_v) begin
            pend_v <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/spike_count_buffer.sv
module spike_count_buffer #(
   parameter int MEM_BITS = 16384,
   parameter int WORD_W   = 16,
   parameter int EXP_MAX  = 8,
   localparam int ADDR_W  = $clog2(MEM_BITS),
   localparam int EXP_W   = $clog2(EXP_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EXP_W-1:0]  cfg_exp,
   input  logic              win_start,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_spike,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              spike_out,
   output logic              busy
);
   localparam int OFF_W   = $clog2(WORD_W);
   localparam int WORD_AW = ADDR_W - OFF_W;
   localparam int ROW_W   = WORD_AW - 1;
   localparam int DW      = 2 * WORD_W;

   if (EXP_MAX < 1 || EXP_MAX > WORD_W) begin : g_bad_exp
      $error("EXP_MAX must lie in 1..WORD_W");
   end
   if (MEM_BITS != (1 << ADDR_W) || WORD_W != (1 << OFF_W)) begin : g_bad_pow2
      $error("MEM_BITS and WORD_W must be powers of two");
   end
   if (MEM_BITS < 4 * WORD_W) begin : g_bad_size
      $error("MEM_BITS must hold at least four words");
   end

   logic               wr_en_w, play_w;
   logic [ADDR_W-1:0]  wr_bitaddr_w, rd_bitaddr_w;
   logic [EXP_MAX-1:0] wr_cnt_w, fetch_cnt_w;
   logic [WORD_AW-1:0] w_lo, w_hi, r_lo, r_hi;
   logic [OFF_W-1:0]   w_off, r_off;
   logic [DW-1:0]      fld_mask, w_mask, w_data, r_join;
   logic [WORD_W-1:0]  rword [2];

   scb_collector #(.ADDR_W(ADDR_W), .EXP_MAX(EXP_MAX), .EXP_W(EXP_W)) u_collector (
      .clk(clk), .rst_n(rst_n), .cfg_exp(cfg_exp), .win_start(win_start),
      .in_addr(in_addr), .in_spike(in_spike), .wr_en(wr_en_w),
      .wr_bitaddr(wr_bitaddr_w), .wr_cnt(wr_cnt_w));

   scb_player #(.ADDR_W(ADDR_W), .EXP_MAX(EXP_MAX), .EXP_W(EXP_W)) u_player (
      .clk(clk), .rst_n(rst_n), .cfg_exp(cfg_exp), .rd_req(rd_req),
      .rd_addr(rd_addr), .fetch_cnt(fetch_cnt_w), .fetch_addr(rd_bitaddr_w),
      .busy(busy), .playing(play_w), .spike_out(spike_out));

   always_comb begin
      fld_mask = ({{(DW-1){1'b0}}, 1'b1} << cfg_exp) - DW'(1);
      w_lo     = wr_bitaddr_w[ADDR_W-1:OFF_W];
      w_hi     = w_lo + WORD_AW'(1);
      w_off    = wr_bitaddr_w[OFF_W-1:0];
      w_mask   = fld_mask << w_off;
      w_data   = (DW'(wr_cnt_w) << w_off) & w_mask;
      r_lo     = rd_bitaddr_w[ADDR_W-1:OFF_W];
      r_hi     = r_lo + WORD_AW'(1);
      r_off    = rd_bitaddr_w[OFF_W-1:0];
      r_join   = {rword[~r_lo[0]], rword[r_lo[0]]};
      fetch_cnt_w = EXP_MAX'((r_join >> r_off) & fld_mask);
   end

   // Even words live in bank 0, odd words in bank 1; a field touches both.
   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic              w_sel_lo, r_sel_lo;
      logic [ROW_W-1:0]  waddr, raddr;
      logic [WORD_W-1:0] wmask, wdata;
      always_comb begin
         w_sel_lo = (w_lo[0] == 1'(b));
         r_sel_lo = (r_lo[0] == 1'(b));
         waddr    = w_sel_lo ? w_lo[WORD_AW-1:1] : w_hi[WORD_AW-1:1];
         raddr    = r_sel_lo ? r_lo[WORD_AW-1:1] : r_hi[WORD_AW-1:1];
         wmask    = w_sel_lo ? w_mask[WORD_W-1:0] : w_mask[DW-1:WORD_W];
         wdata    = w_sel_lo ? w_data[WORD_W-1:0] : w_data[DW-1:WORD_W];
      end
      scb_bank #(.WORD_W(WORD_W), .ROW_W(ROW_W)) u_bank (
         .clk(clk), .we(wr_en_w), .waddr(waddr), .wmask(wmask), .wdata(wdata),
         .raddr(raddr), .rdata(rword[b]));
   end
endmodule

// File: rtl/spike_count_buffer_chk.sv
module spike_count_buffer_chk #(
   parameter int EXP_MAX = 8,
   parameter int EXP_W   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [EXP_W-1:0]   cfg_exp,
   input logic               rd_req,
   input logic               busy,
   input logic               playing,
   input logic               wr_en,
   input logic [EXP_MAX-1:0] wr_cnt
);
   localparam int CNT_W = EXP_MAX + 1;

   logic [CNT_W-1:0] win_len, play_len;
   assign win_len = CNT_W'(1) << cfg_exp;

   always_ff @(posedge clk) begin
      if (!rst_n)       play_len <= '0;
      else if (playing) play_len <= play_len + CNT_W'(1);
      else              play_len <= '0;
   end

   // R3: a committed field always fits in n bits
   assert_count_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (CNT_W'(wr_cnt) < win_len));

   // R7: an idle request is accepted at once
   assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && rd_req) |=> busy);

   // R7, R9: each output window lasts exactly 2^n cycles
   assert_window_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(playing) |-> (play_len == win_len));

   // R8: a request seen while busy keeps the port busy (it is held)
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_req) |=> busy);

   // R8: a window never starts without the fetch cycles before it
   assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(playing) |-> $past(busy));
endmodule

bind spike_count_buffer spike_count_buffer_chk #(.EXP_MAX(EXP_MAX), .EXP_W(EXP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_exp(cfg_exp), .rd_req(rd_req), .busy(busy),
   .playing(play_w), .wr_en(wr_en_w), .wr_cnt(wr_cnt_w));

// File: tb/spike_count_buffer_bench.sv
module spike_count_buffer_bench;
   localparam int IDX_W = 14;
   localparam int EXP_W = 4;

   typedef struct {
      int    val;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic             rst_n, win_start, in_spike, rd_req, spike_out, busy;
   logic [EXP_W-1:0] cfg_exp;
   logic [IDX_W-1:0] in_addr, rd_addr;

   spike_count_buffer u_spike_count_buffer (
      .clk(clk), .rst_n(rst_n), .cfg_exp(cfg_exp), .win_start(win_start),
      .in_addr(in_addr), .in_spike(in_spike), .rd_req(rd_req), .rd_addr(rd_addr),
      .spike_out(spike_out), .busy(busy));

   int            n_tests = 0, n_fail = 0, cur_exp = 4, chain_cnt = 0;
   bit            done = 0;
   logic [1023:0] ref_bits = '0;
   exp_t          exp_q[$];

   task automatic check(bit ok, string tag, int act, int expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic int ref_get(int idx);
      int v = 0;
      for (int b = 0; b < cur_exp; b++) v |= int'(ref_bits[idx*cur_exp+b]) << b;
      return v;
   endfunction

   task automatic ref_put(int idx, int val);
      for (int b = 0; b < cur_exp; b++) ref_bits[idx*cur_exp+b] = val[b];
   endtask

   task automatic set_exp(int n);
      @(posedge clk); #1;
      cur_exp = n;
      cfg_exp = EXP_W'(n);
   endtask

   // Driver: a window of 2^n cycles holding c spikes in random positions
   task automatic write_entry(int idx, int c, int glitch_idx = -1);
      int L = 1 << cur_exp;
      bit train[256];
      for (int i = 0; i < 256; i++) train[i] = (i < c);
      for (int i = L - 1; i > 0; i--) begin
         int j = $urandom_range(i, 0);
         bit t = train[i];
         train[i] = train[j];
         train[j] = t;
      end
      @(posedge clk); #1;
      win_start = 1'b1; in_addr = IDX_W'(idx); in_spike = train[0];
      for (int i = 1; i < L; i++) begin
         @(posedge clk); #1;
         win_start = (glitch_idx >= 0) && (i == L / 2);
         in_addr   = win_start ? IDX_W'(glitch_idx) : IDX_W'(idx);
         in_spike  = train[i];
      end
      @(posedge clk); #1;
      win_start = 1'b0; in_spike = 1'b0;
      ref_put(idx, (c >= L) ? L - 1 : c);
      @(posedge clk);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   task automatic read_entry(int idx, string tag);
      exp_t e;
      wait_idle();
      @(posedge clk); #1;
      rd_req = 1'b1; rd_addr = IDX_W'(idx);
      e.val = ref_get(idx); e.tag = tag;
      exp_q.push_back(e);
      @(posedge clk); #1;
      rd_req = 1'b0;
      @(negedge clk);
      check(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
      wait_idle();
   endtask

   // Monitor: splits output activity into windows and scores each one
   initial begin
      bit   more, gap_ok, busy_ok;
      int   L, cnt;
      exp_t e;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (busy) begin
            more = 1'b1;
            while (more) begin
               L = 1 << cur_exp;
               cnt = 0;
               busy_ok = 1'b1;
               gap_ok = !spike_out;
               @(negedge clk);
               gap_ok = gap_ok && !spike_out;
               check(gap_ok, "R7 silent fetch cycles", int'(!gap_ok), 0);
               for (int i = 0; i < L; i++) begin
                  @(negedge clk);
                  if (!busy) busy_ok = 1'b0;
                  cnt += int'(spike_out);
               end
               check(busy_ok, "R9 busy through window", int'(busy_ok), 1);
               if (exp_q.size() == 0) begin
                  check(1'b0, "R6 unexpected window", cnt, -1);
               end else begin
                  e = exp_q.pop_front();
                  check(cnt == e.val, e.tag, cnt, e.val);
               end
               @(negedge clk);
               if (busy) chain_cnt++;
               else begin
                  more = 1'b0;
                  check(!spike_out, "R9 idle after window", int'(spike_out), 0);
               end
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int c0;
      int cnt4[8] = '{0, 5, 15, 16, 9, 1, 12, 7};
      rst_n = 1'b0; win_start = 1'b0; in_spike = 1'b0; rd_req = 1'b0;
      in_addr = '0; rd_addr = '0; cfg_exp = EXP_W'(4);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!busy && !spike_out, "R1 in reset", int'(busy) + int'(spike_out), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !spike_out, "R1 after reset", int'(busy) + int'(spike_out), 0);

      // R2 / R3: n = 4, including an all-ones window
      for (int i = 0; i < 8; i++) write_entry(i, cnt4[i]);
      for (int i = 0; i < 8; i++) read_entry(i, (cnt4[i] == 16) ? "R3 saturated" : "R2 R6 stored count");

      // R4: stray start inside a window, spikes outside windows
      write_entry(8, 6);
      write_entry(9, 10, 8);
      @(posedge clk); #1 in_spike = 1'b1;
      repeat (6) @(posedge clk);
      #1 in_spike = 1'b0;
      write_entry(10, 3);
      read_entry(8, "R4 untouched by stray start");
      read_entry(9, "R4 window kept its index");
      read_entry(10, "R4 outside spikes ignored");

      // R5: packed fields crossing word boundaries
      set_exp(3);
      write_entry(4, $urandom_range(8, 0));
      write_entry(5, 8);
      write_entry(6, $urandom_range(8, 0));
      write_entry(10, $urandom_range(8, 0));
      write_entry(11, $urandom_range(8, 0));
      write_entry(5, $urandom_range(7, 0));
      read_entry(4, "R5 neighbour below");
      read_entry(5, "R5 field across word 0/1");
      read_entry(6, "R5 neighbour above");
      read_entry(10, "R5 field across word 1/2");
      read_entry(11, "R5 next field");
      set_exp(5);
      write_entry(3, $urandom_range(32, 0));
      write_entry(6, 32);
      write_entry(4, $urandom_range(31, 0));
      read_entry(3, "R5 n5 across word 0/1");
      read_entry(6, "R5 R3 n5 across word 1/2");
      read_entry(4, "R5 n5 middle");

      // R6: longest and shortest windows
      set_exp(8);
      write_entry(0, 256);
      write_entry(1, $urandom_range(255, 0));
      write_entry(2, 0);
      write_entry(3, 128);
      for (int i = 0; i < 4; i++) read_entry(i, "R6 R3 n8 count");
      set_exp(1);
      write_entry(0, 0);
      write_entry(1, 1);
      write_entry(2, 2);
      write_entry(3, 1);
      for (int i = 0; i < 4; i++) read_entry(i, "R6 R3 n1 count");

      // R8: request while busy is held and chained
      set_exp(4);
      write_entry(0, 11);
      write_entry(1, 4);
      wait_idle();
      c0 = chain_cnt;
      @(posedge clk); #1;
      rd_req = 1'b1; rd_addr = IDX_W'(0);
      exp_q.push_back('{11, "R8 first window"});
      @(posedge clk); #1 rd_req = 1'b0;
      repeat (3) @(posedge clk);
      #1 rd_req = 1'b1; rd_addr = IDX_W'(1);
      exp_q.push_back('{4, "R8 held window"});
      @(posedge clk); #1 rd_req = 1'b0;
      wait_idle();
      check(chain_cnt == c0 + 1, "R8 chained window", chain_cnt - c0, 1);
      check(exp_q.size() == 0, "R8 all windows delivered", exp_q.size(), 0);

      repeat (4) @(posedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule